// File: doc/BRIEF.md
# UART Baud Rate Tick Generator

This block derives the timing enables for a serial transmitter and receiver from the core clock and a 16-bit programmable divisor. It produces two single-cycle enables. The sample tick fires once every divisor-count core clock cycles and drives 16x oversampling. The bit tick fires on every sixteenth sample tick and marks one bit period at the baud rate. The baud rate is therefore the core clock frequency over sixteen times the divisor.

Software writes the divisor one byte at a time. A low-byte write only fills a staging register. The later high-byte write moves both bytes into the working divisor in one step and restarts both counters, so a half-written value never reaches the tick stream. A divisor of zero stops both ticks. A divisor of one is not allowed: it raises a status flag, and the ticks stay stopped until a legal value of two or more is loaded. Register writes are taken as synchronous to the core clock.

Top module: `uart_tick_gen`

## Requirements
- R1: After a synchronous reset the working divisor is 0, both counters are cleared, `sample_tick` and `bit_tick` are low, and `div_illegal` is low.
- R2: A write with `wr_lo` high only stores `wr_data` as the staged low byte. It has no effect on the ticks or on the working divisor, whether the block is stopped or running.
- R3: A write with `wr_hi` high loads `{wr_data, staged low byte}` as the working divisor, with `wr_data` in bits 15:8, and clears both counters. For a legal divisor DL, the first `sample_tick` is high in the cycle that follows the DL-th rising edge after the edge that sampled `wr_hi`.
- R4: For a constant legal divisor DL (2 or more), `sample_tick` is high for exactly one cycle and repeats every DL cycles with no jitter.
- R5: `bit_tick` is high only together with `sample_tick`, on every 16th sample tick counted from the load, so it repeats every 16 x DL cycles.
- R6: With a working divisor of 0, neither tick is produced and `div_illegal` stays low.
- R7: With a working divisor of 1, `div_illegal` is high and neither tick is produced. Loading a legal divisor clears the flag and restarts the ticks.
- R8: A high-byte write in the cycle where a sample tick or bit tick is due suppresses that tick. The next ticks are then timed from the new load as in R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_lo | input | 1 | Strobe: store `wr_data` as the staged low divisor byte |
| wr_hi | input | 1 | Strobe: load `wr_data` as the high byte and commit the divisor |
| wr_data | input | 8 | Divisor byte being written |
| sample_tick | output | 1 | One-cycle 16x oversampling enable |
| bit_tick | output | 1 | One-cycle enable at the baud rate |
| div_illegal | output | 1 | High while the working divisor is 1 |

## Verification
Two functions can fall in the same cycle: a divisor commit and the counter wrap that would issue a tick. To provoke this, the bench reloads the divisor on the exact edge where a sample tick is due with DL = 4. It does the same on the edge where the 16th sample tick, and so the bit tick, is due with DL = 2. The bench passes when that cycle shows neither tick and the following ticks fall exactly DL and 16 x DL cycles after the reload edge. A low-byte write held during a running stream is judged by the tick spacing, which must not change.

// File: rtl/uart_tick_gen.sv
module uart_tick_gen #(
  parameter int DIV_W      = 16,
  parameter int OVERSAMPLE = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_lo,
  input  logic               wr_hi,
  input  logic [DIV_W/2-1:0] wr_data,
  output logic               sample_tick,
  output logic               bit_tick,
  output logic               div_illegal
);
  localparam int HALF_W = DIV_W / 2;
  localparam int SUB_W  = $clog2(OVERSAMPLE);

  logic [HALF_W-1:0] lo_stage;
  logic [DIV_W-1:0]  div_q;
  logic [DIV_W-1:0]  cnt_q;
  logic [SUB_W-1:0]  sub_q;
  logic              samp_q;
  logic              bit_q;
  logic              run;
  logic              due;
  logic              last_sub;

  assign run      = div_q > DIV_W'(1);
  assign due      = run && (cnt_q == div_q - DIV_W'(1));
  assign last_sub = sub_q == SUB_W'(OVERSAMPLE - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_stage <= '0;
      div_q    <= '0;
      cnt_q    <= '0;
      sub_q    <= '0;
      samp_q   <= 1'b0;
      bit_q    <= 1'b0;
    end else begin
      if (wr_lo) lo_stage <= wr_data;
      if (wr_hi) begin
        div_q  <= {wr_data, lo_stage};
        cnt_q  <= '0;
        sub_q  <= '0;
        samp_q <= 1'b0;
        bit_q  <= 1'b0;
      end else begin
        samp_q <= due;
        bit_q  <= due && last_sub;
        if (!run) begin
          cnt_q <= '0;
          sub_q <= '0;
        end else if (due) begin
          cnt_q <= '0;
          sub_q <= last_sub ? '0 : sub_q + 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign sample_tick = samp_q;
  assign bit_tick    = bit_q;
  assign div_illegal = div_q == DIV_W'(1);
endmodule

module uart_tick_gen_chk #(
  parameter int DIV_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_hi,
  input logic [DIV_W-1:0] div,
  input logic             sample_tick,
  input logic             bit_tick
);
  a_r4_one_cycle: assert property (@(posedge clk) disable iff (rst)
    sample_tick |=> !sample_tick);

  a_r5_bit_with_sample: assert property (@(posedge clk) disable iff (rst)
    bit_tick |-> sample_tick);

  a_r6_halted: assert property (@(posedge clk) disable iff (rst)
    (div < DIV_W'(2)) |-> (!sample_tick && !bit_tick));

  a_r8_load_quiet: assert property (@(posedge clk) disable iff (rst)
    wr_hi |=> (!sample_tick && !bit_tick));
endmodule

bind uart_tick_gen uart_tick_gen_chk #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst(rst), .wr_hi(wr_hi), .div(div_q),
  .sample_tick(sample_tick), .bit_tick(bit_tick)
);

// File: tb/uart_tick_gen_test.sv
module uart_tick_gen_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_lo = 1'b0;
  logic       wr_hi = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       sample_tick, bit_tick, div_illegal;
  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  uart_tick_gen uut (
    .clk(clk), .rst(rst), .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_data(wr_data),
    .sample_tick(sample_tick), .bit_tick(bit_tick), .div_illegal(div_illegal)
  );

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  // Ends at the negedge just after the edge that sampled wr_hi (cycle 0).
  task automatic load(input int dl);
    @(negedge clk);
    wr_lo = 1'b1; wr_data = dl[7:0];
    @(negedge clk);
    wr_lo = 1'b0; wr_hi = 1'b1; wr_data = dl[15:8];
    @(negedge clk);
    wr_hi = 1'b0;
  endtask

  // Walks cycles first..last after a load and compares both ticks per cycle.
  task automatic run_check(input int dl, input int first, input int last, input string tag);
    int bad = 0;
    int at = 0, act = 0, exp = 0;
    bit es, eb;
    for (int k = first; k <= last; k++) begin
      @(negedge clk);
      es = (k % dl) == 0;
      eb = (k % (16 * dl)) == 0;
      if ((sample_tick !== es || bit_tick !== eb) && bad == 0) begin
        at = k; act = {sample_tick, bit_tick}; exp = {es, eb};
      end
      if (sample_tick !== es || bit_tick !== eb) bad++;
    end
    check(bad == 0, $sformatf("%s dl=%0d ticks {s,b} at cycle %0d", tag, dl, at), act, exp);
  endtask

  task automatic quiet_check(input int cycles, input string tag);
    int seen = 0;
    for (int k = 0; k < cycles; k++) begin
      @(negedge clk);
      if (sample_tick || bit_tick) seen++;
    end
    check(seen == 0, $sformatf("%s tick cycles", tag), seen, 0);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(div_illegal == 1'b0, "R1 div_illegal after reset", div_illegal, 0);
    quiet_check(20, "R1 idle after reset");
  endtask

  task automatic t_lo_only;
    @(negedge clk);
    wr_lo = 1'b1; wr_data = 8'h05;
    @(negedge clk);
    wr_lo = 1'b0;
    quiet_check(50, "R2 low byte alone while stopped");
    load(3);
    run_check(3, 1, 30, "R2 before low write");
    wr_lo = 1'b1; wr_data = 8'h77;
    run_check(3, 31, 60, "R2 low write while running");
    wr_lo = 1'b0;
  endtask

  task automatic t_spacing(input int dl, input int cycles);
    load(dl);
    run_check(dl, 1, cycles, "R3 R4 R5 spacing");
  endtask

  task automatic t_zero;
    load(5);
    run_check(5, 1, 20, "R3 running before stop");
    load(0);
    check(div_illegal == 1'b0, "R6 flag with divisor 0", div_illegal, 0);
    quiet_check(300, "R6 divisor 0");
  endtask

  task automatic t_one;
    load(1);
    check(div_illegal == 1'b1, "R7 flag with divisor 1", div_illegal, 1);
    quiet_check(300, "R7 divisor 1");
    load(5);
    check(div_illegal == 1'b0, "R7 flag after legal load", div_illegal, 0);
    run_check(5, 1, 100, "R7 restart");
  endtask

  task automatic t_collide_sample;
    load(4);
    run_check(4, 1, 3, "R8 before collision");
    wr_hi = 1'b1; wr_data = 8'h00;
    @(negedge clk);
    wr_hi = 1'b0;
    check(sample_tick == 1'b0, "R8 sample tick suppressed by reload", sample_tick, 0);
    run_check(4, 1, 80, "R8 after sample collision");
  endtask

  task automatic t_collide_bit;
    load(2);
    run_check(2, 1, 31, "R8 before bit collision");
    wr_hi = 1'b1; wr_data = 8'h00;
    @(negedge clk);
    wr_hi = 1'b0;
    check(bit_tick == 1'b0 && sample_tick == 1'b0, "R8 bit tick suppressed by reload",
          {sample_tick, bit_tick}, 0);
    run_check(2, 1, 70, "R8 after bit collision");
  endtask

  initial begin
    t_reset();
    t_lo_only();
    t_spacing(2, 100);
    t_spacing(3, 200);
    t_spacing(16'h0C35, 16 * 16'h0C35 + 5);
    t_spacing(16'hFFFF, 16'hFFFF + 5);
    t_zero();
    t_one();
    t_collide_sample();
    t_collide_bit();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d cycles", 200000, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule